// File: doc/BRIEF.md
# Lock-Wait Alarm Timer

This block checks whether the reference input now chosen for the primary DPLL reaches phase lock within a programmable number of seconds. It covers five reference inputs. Indices 0 to 2 are the single-ended inputs and indices 3 and 4 are the differential inputs. An external one-second tick drives all timing. The window length is the product of a 6-bit timeout value and a 2-bit multiplier.

While the selection is valid, lock is absent and the selection stays the same, a counter advances once per tick. When the counter reaches the window, the alarm bit of the selected input is set. An input with its alarm set is reported as disqualified for primary DPLL locking.

Alarms can be cleared in one of two ways, picked by a mode bit:
- by a write-one-to-clear strobe;
- automatically, one window after the alarm was raised.

A single-cycle interrupt pulse marks every new alarm.

Top module: `lock_alarm_timer`

## Requirements
- R1: With window P = tmo_value × tmo_mult ≥ 1, the alarm bit of the selected input is set on the P-th tick counted while dpll_locked is low and sel_idx is unchanged. It is not set before that tick.
- R2: With P = 0, the alarm is set on the first tick at which lock is absent and the selection is unchanged.
- R3: The wait counter restarts from zero in two cases: in any cycle where sel_idx differs from its value in the previous cycle, and while dpll_locked is high. No alarm is raised while dpll_locked is high.
- R4: Alarm bit i belongs to input index i. Bits 0–2 are the single-ended inputs and bits 3–4 are the differential inputs. When sel_valid is low or sel_idx is 5, 6 or 7, no alarm is raised.
- R5: With auto_clear = 0, a cycle with wr_stb high and wr_clr bit i = 1 clears alarm i. A 0 in wr_clr bit i leaves alarm i unchanged.
- R6: With auto_clear = 1, an alarm clears on the P-th tick after it was raised, or on the next tick when P = 0. Writes have no effect in this mode.
- R7: When an alarm is raised in the same cycle that would clear it, the raise wins and the alarm stays set.
- R8: disq equals alarm bit for bit.
- R9: irq is high for exactly the cycle in which any alarm bit first reads 1 after reading 0.
- R10: A synchronous active-low reset clears all alarms, counters, disq and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_sec | input | 1 | One-cycle pulse once per second |
| sel_valid | input | 1 | A reference is selected for the primary DPLL |
| sel_idx | input | 3 | Index of the selected reference (0–4) |
| dpll_locked | input | 1 | Primary DPLL is phase locked |
| tmo_value | input | 6 | Timeout value |
| tmo_mult | input | 2 | Timeout multiplier |
| auto_clear | input | 1 | 1: alarms expire after one window; 0: write-one-to-clear |
| wr_stb | input | 1 | Clear-write strobe |
| wr_clr | input | 5 | Per-input clear bits, one per alarm |
| alarm | output | 5 | Per-input alarm flags |
| disq | output | 5 | Per-input disqualify flags |
| irq | output | 1 | Pulse on any new alarm |

## Verification
The assertions rely on four things about the inputs:
- tick_sec is a single-cycle pulse;
- the timeout fields are quasi-static compared with the window they define;
- wr_clr matters only when wr_stb is high;
- sel_idx is meaningful only when sel_valid is high.

The random stimulus follows these rules. Ticks are single-cycle pulses. The timeout fields and the clear mode change only a few times across the run. Lock and selection change rarely enough for windows to expire, and the stimulus also reaches out-of-range indices and writes with mixed bit patterns.

// File: rtl/lat_pkg.sv
// Package: shared sizes for the lock-wait alarm timer.
// Assumes the window never exceeds 63 x 3 ticks.
package lat_pkg;
    parameter int NUM_IN = 5;
    parameter int TV_W   = 6;
    parameter int MUL_W  = 2;
    parameter int SEL_W  = 3;
    localparam int MAX_WIN = ((1 << TV_W) - 1) * ((1 << MUL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_WIN + 1);
    typedef logic [CNT_W-1:0] win_t;
endpackage

// File: rtl/lat_lock_timer.sv
// Module: counts ticks while the selected reference stays unlocked and unchanged.
// It fires once the window is reached.
// Assumes tick_sec is a single-cycle pulse.
module lat_lock_timer
    import lat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             sel_valid,
    input  logic [SEL_W-1:0] sel_idx,
    input  logic             dpll_locked,
    input  win_t             period,
    output logic             fire
);
    win_t             cnt_q;
    logic [SEL_W-1:0] sel_prev_q;
    logic             sel_change;
    logic             in_range;
    logic             armed;
    logic [CNT_W:0]   cnt_inc;

    // Decode the selection state and the window comparison.
    always_comb begin
        sel_change = (sel_idx != sel_prev_q);
        in_range   = sel_valid && (sel_idx < SEL_W'(NUM_IN));
        armed      = in_range && !dpll_locked && !sel_change;
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        fire       = armed && tick_sec && (cnt_inc >= {1'b0, period});
    end

    // Remember the previous selection so a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev_q <= '0;
        else        sel_prev_q <= sel_idx;
    end

    // Wait counter: restart on lock, change or firing; advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!armed)        cnt_q <= '0;
        else if (tick_sec) begin
            if (fire)           cnt_q <= '0;
            else                cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        dpll_locked |=> (cnt_q == '0)); // R3
    AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (tick_sec && !dpll_locked && sel_valid)); // R1
endmodule

// File: rtl/lat_alarm_slot.sv
// Module: one alarm flag with its expiry age counter.
// A raise beats any clear that falls in the same cycle.
// Assumes period is stable while an alarm is aging.
module lat_alarm_slot
    import lat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_sec,
    input  logic raise,
    input  logic auto_clear,
    input  logic wr_stb,
    input  logic wr_bit,
    input  win_t period,
    output logic alarm_q
);
    win_t           age_q;
    logic [CNT_W:0] age_inc;
    logic           expire;
    logic           sw_clear;

    // Work out the two ways this alarm can clear.
    always_comb begin
        age_inc  = {1'b0, age_q} + 1'b1;
        expire   = auto_clear && tick_sec && (age_inc >= {1'b0, period});
        sw_clear = !auto_clear && wr_stb && wr_bit;
    end

    // Alarm flag and age counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            age_q   <= '0;
        end else if (raise) begin
            alarm_q <= 1'b1;
            age_q   <= '0;
        end else if (alarm_q && (expire || sw_clear)) begin
            alarm_q <= 1'b0;
            age_q   <= '0;
        end else if (alarm_q && auto_clear && tick_sec) begin
            age_q   <= age_inc[CNT_W-1:0];
        end
    end

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> alarm_q); // R7
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_clear && wr_stb && wr_bit && !raise) |=> !alarm_q); // R5
    AST_W1C_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_clear && !(wr_stb && wr_bit) && alarm_q) |=> alarm_q); // R5
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clear && alarm_q && !tick_sec) |=> alarm_q); // R6
endmodule

// File: rtl/lat_irq_edge.sv
// Module: turns a 0-to-1 change on any alarm bit into a one-cycle pulse.
// Assumes the alarm vector is registered upstream.
module lat_irq_edge
    import lat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] alarm,
    output logic              irq
);
    logic [NUM_IN-1:0] prev_q;

    // Hold last cycle's alarm vector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= alarm;
    end

    // Pulse while a bit reads set for the first time.
    always_comb irq = |(alarm & ~prev_q);

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (alarm != '0)); // R9
endmodule

// File: rtl/lock_alarm_timer.sv
// Module: top of the lock-wait alarm timer.
// It holds one shared wait timer, one alarm slot per reference input and an interrupt edge detector.
// Assumes the one-second tick is a single-cycle pulse in clk.
module lock_alarm_timer
    import lat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic              sel_valid,
    input  logic [SEL_W-1:0]  sel_idx,
    input  logic              dpll_locked,
    input  logic [TV_W-1:0]   tmo_value,
    input  logic [MUL_W-1:0]  tmo_mult,
    input  logic              auto_clear,
    input  logic              wr_stb,
    input  logic [NUM_IN-1:0] wr_clr,
    output logic [NUM_IN-1:0] alarm,
    output logic [NUM_IN-1:0] disq,
    output logic              irq
);
    win_t period;
    logic fire;

    // Window length is the product of the two fields.
    always_comb period = win_t'(tmo_value) * win_t'(tmo_mult);

    lat_lock_timer u_timer (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .sel_valid(sel_valid),
        .sel_idx(sel_idx), .dpll_locked(dpll_locked), .period(period), .fire(fire)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_slot
        logic raise_i;
        // Route the timer firing to the slot of the selected input.
        always_comb raise_i = fire && (sel_idx == SEL_W'(i));
        lat_alarm_slot u_slot (
            .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .raise(raise_i),
            .auto_clear(auto_clear), .wr_stb(wr_stb), .wr_bit(wr_clr[i]),
            .period(period), .alarm_q(alarm[i])
        );
    end

    // A flagged input is out of the running for primary locking.
    always_comb disq = alarm;

    lat_irq_edge u_irq (.clk(clk), .rst_n(rst_n), .alarm(alarm), .irq(irq));

    AST_DISQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm == '0) |-> (disq == '0)); // R8
    AST_NO_ALARM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_locked && alarm == '0 && !fire) |=> (alarm == '0)); // R3
endmodule

// File: tb/lock_alarm_timer_tb_top.sv
module lock_alarm_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 1'b0, sel_valid = 1'b0, dpll_locked = 1'b1;
    logic [2:0] sel_idx = '0;
    logic [5:0] tmo_value = '0;
    logic [1:0] tmo_mult = '0;
    logic       auto_clear = 1'b0, wr_stb = 1'b0;
    logic [4:0] wr_clr = '0;
    logic [4:0] alarm, disq;
    logic       irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state
    int         m_cnt, m_prev_sel;
    int         m_age[5];
    logic [4:0] m_al, m_al_old;

    always #4 clk = ~clk;

    lock_alarm_timer dut_i (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int win();
        return int'(tmo_value) * int'(tmo_mult);
    endfunction

    // expected state after one clock edge, from the requirements
    task automatic model_edge();
        int  p = win();
        bit  ch = (int'(sel_idx) != m_prev_sel);
        bit  armed = sel_valid && (sel_idx < 5) && !dpll_locked && !ch;
        bit  fire = armed && tick_sec && (m_cnt + 1 >= p);
        m_al_old = m_al;
        if (!armed) m_cnt = 0;
        else if (tick_sec) m_cnt = fire ? 0 : m_cnt + 1;
        for (int i = 0; i < 5; i++) begin
            if (fire && sel_idx == 3'(i)) begin
                m_al[i] = 1'b1; m_age[i] = 0;
            end else if (m_al[i]) begin
                if (auto_clear && tick_sec) begin
                    if (m_age[i] + 1 >= p) begin m_al[i] = 1'b0; m_age[i] = 0; end
                    else m_age[i]++;
                end else if (!auto_clear && wr_stb && wr_clr[i]) begin
                    m_al[i] = 1'b0; m_age[i] = 0;
                end
            end
        end
        m_prev_sel = int'(sel_idx);
    endtask

    // one clock: inputs already set at negedge; compare at next negedge
    task automatic cyc(bit t, bit w, logic [4:0] wd);
        tick_sec = t; wr_stb = w; wr_clr = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R1 alarm", alarm, m_al);
        chk("R8 disq", disq, m_al);
        chk("R9 irq", irq, |(m_al & ~m_al_old));
        tick_sec = 0; wr_stb = 0; wr_clr = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_cnt = 0; m_prev_sel = 0; m_al = '0; m_al_old = '0;
        for (int i = 0; i < 5; i++) m_age[i] = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset alarm", alarm, 0);
        chk("R10 reset disq", disq, 0);
        chk("R10 reset irq", irq, 0);
        rst_n = 1'b1;

        // R1: window 2, input 1, write-one-to-clear mode
        tmo_value = 2; tmo_mult = 1; auto_clear = 0;
        sel_valid = 1; sel_idx = 1; dpll_locked = 0;
        cyc(0, 0, 0);
        cyc(1, 0, 0); chk("R1 not early", alarm, 0);
        cyc(1, 0, 0); chk("R1 raised", alarm, 5'b00010);
        chk("R9 pulse", irq, 1); chk("R8 disq", disq, 5'b00010);
        cyc(0, 0, 0); chk("R9 single cycle", irq, 0);
        // R5
        dpll_locked = 1;
        cyc(0, 1, 5'b11101); chk("R5 zero keeps", alarm, 5'b00010);
        cyc(0, 1, 5'b00010); chk("R5 one clears", alarm, 0);
        // R3: locked ticks raise nothing
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); chk("R3 locked", alarm, 0);
        dpll_locked = 0; cyc(0, 0, 0);
        sel_idx = 2; cyc(1, 0, 0); chk("R3 change restarts", alarm, 0);
        cyc(1, 0, 0); chk("R3 after change", alarm, 0);
        cyc(1, 0, 0); chk("R1 input 2", alarm, 5'b00100);
        // R2: zero window
        dpll_locked = 1; cyc(0, 1, 5'h1f);
        tmo_value = 0; sel_idx = 3; cyc(0, 0, 0);
        dpll_locked = 0; cyc(0, 0, 0);
        cyc(1, 0, 0); chk("R2 zero window", alarm, 5'b01000);
        // R4: out of range index
        dpll_locked = 1; cyc(0, 1, 5'h1f);
        sel_idx = 6; tmo_value = 1; cyc(0, 0, 0);
        dpll_locked = 0; cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
        chk("R4 index 6", alarm, 0);
        sel_valid = 0; sel_idx = 4; cyc(1, 0, 0); cyc(1, 0, 0);
        chk("R4 not valid", alarm, 0);
        // R6: auto clear with window 3
        sel_valid = 1; dpll_locked = 1; tmo_value = 3; auto_clear = 1; sel_idx = 0;
        cyc(0, 0, 0); dpll_locked = 0;
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); chk("R1 input 0", alarm, 5'b00001);
        dpll_locked = 1;
        cyc(0, 1, 5'h1f); chk("R6 write ignored", alarm, 5'b00001);
        cyc(1, 0, 0); cyc(1, 0, 0); chk("R6 not yet", alarm, 5'b00001);
        cyc(1, 0, 0); chk("R6 expired", alarm, 0);
        // R7: raise beats a same-cycle clear
        auto_clear = 0; tmo_value = 0; sel_idx = 4; cyc(0, 0, 0);
        dpll_locked = 0; cyc(0, 0, 0);
        cyc(1, 0, 0); chk("R7 raised", alarm, 5'b10000);
        cyc(1, 1, 5'b10000); chk("R7 raise wins", alarm, 5'b10000);

        // random phase
        for (int n = 0; n < 20000; n++) begin
            if ($urandom_range(0, 499) == 0) begin
                tmo_value = 6'($urandom_range(0, 4));
                tmo_mult = 2'($urandom_range(0, 3));
                auto_clear = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 59) == 0) dpll_locked = ~dpll_locked;
            if ($urandom_range(0, 79) == 0) sel_idx = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 199) == 0) sel_valid = ~sel_valid;
            cyc(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 9) == 0),
                5'($urandom_range(0, 31)));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule